// File: doc/BRIEF.md
# Real-Time Memory Monitor Serializer

This block watches four data-memory locations and streams their contents out on a single serial line at the start of every compute pass. Each of the four slots has its own address select field. When a pass-start strobe arrives while the monitor is enabled, the block reads the slot locations one after another through a simple read port. It sends each word as a fixed frame: a flag bit, the 32 data bits with the most significant bit first, and two trailing low bits.

A companion serial clock runs at half the system clock rate. It is low in the first half of each bit period and high in the second half, so the data line changes on its falling edge and a receiver samples on its rising edge. The clock only toggles when its output enable is set. The four frames run back to back, and the data line is parked low whenever no transfer is in progress.

Top module: `rtm_serializer`

## Requirements
- R1: While reset is asserted, serial data, serial clock and the memory read enable are all low.
- R2: A pass-start strobe sampled high while enabled and idle raises the memory read enable in the very next cycle, with the address of slot 0.
- R3: While the enable input is low, a pass-start strobe starts no transfer: no memory read occurs and both serial outputs stay low.
- R4: Each bit period lasts exactly two system clock cycles. Each word occupies exactly 35 bit periods, the four words follow each other with no gap, and a whole pass takes 281 cycles from the sampled strobe until the block is idle again.
- R5: The first bit of each word is a flag: 1 for the word of slot 0 and 0 for the words of slots 1 to 3.
- R6: Bit periods 1 to 32 of a word carry the fetched memory word, bit 31 first and bit 0 last. Bit periods 33 and 34 are low.
- R7: Each word is read exactly one cycle before its flag bit appears on the data line. The read address of slot k is bits [2k+1:2k] of the slot select bus, and one read happens per word.
- R8: The serial data line is low whenever no transfer is in progress.
- R9: The serial clock is high only in the second cycle of a bit period during a transfer, and only if the clock-output enable was high at the edge that started that half. Otherwise it is low.
- R10: A pass-start strobe that arrives while a transfer is running is ignored. A new pass can start no earlier than one cycle after the previous one has ended.
- R11: Dropping the enable input in the middle of a pass does not cut the pass short: all four words are still sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| monEn | input | 1 | Monitor enable; gates the start of a pass |
| ckOutEn | input | 1 | Serial clock output enable |
| passStart | input | 1 | Start-of-compute-pass strobe |
| slotSel | input | 8 | Four 2-bit slot address fields, slot k in bits [2k+1:2k] |
| memRdEn | output | 1 | Memory read strobe, one cycle per word |
| memAddr | output | 2 | Memory read address |
| memRdData | input | 32 | Read data, valid in the same cycle as the address |
| serData | output | 1 | Serial data line |
| serClk | output | 1 | Gated serial clock line |

## Verification
Every bit on the data line is tied to a single count since the sampled strobe. A bit or word counter that slips by one therefore shows up on the ports at once: a misplaced flag or data bit appears within one bit period, and a stray or missing read strobe appears at the word boundary. A controller state that wrongly accepts a strobe while busy, or ends a pass early, changes the read-strobe count of that pass. It also moves the moment at which the data line parks low. The gated clock is compared against the enable value sampled at every second edge, so a gating error surfaces within two cycles.

// File: rtl/rtm_pkg.sv
package rtm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } rtmState_e;

  // Actions the controller requests for the coming clock edge.
  typedef struct packed {
    logic load;      // capture memory read data into the shift register
    logic setFlag;   // drive the flag bit
    logic flagBit;   // value of the flag bit
    logic shiftOut;  // drive shift register MSB and shift left
    logic setZero;   // drive a low bit
    logic clkRise;   // serial clock high (if enabled)
    logic clkFall;   // serial clock low
  } rtmStrobe_t;

endpackage

// File: rtl/rtm_ctrl.sv
module rtm_ctrl
  import rtm_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter int TRAIL_BITS = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        monEn,
  input  logic                        passStart,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotSel,
  output logic                        memRdEn,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        idle,
  output rtmStrobe_t                  strb
);

  localparam int FRAME_BITS = 1 + DATA_W + TRAIL_BITS;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int WORD_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0]  DATA_END  = BIT_W'(DATA_W);
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(NUM_SLOTS - 1);

  rtmState_e          state;
  logic [WORD_W-1:0]  wordIdx;
  logic [BIT_W-1:0]   bitIdx;
  logic               phase;
  logic [WORD_W-1:0]  addrWord;
  logic               lastBit;
  logic               lastWord;

  logic [ADDR_W-1:0]  slotAddr [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slotAddr[s] = slotSel[s*ADDR_W +: ADDR_W];
  end

  assign lastBit  = (bitIdx == LAST_BIT);
  assign lastWord = (wordIdx == LAST_WORD);
  assign idle     = (state == ST_IDLE);
  assign memAddr  = slotAddr[addrWord];

  always_comb begin
    strb     = '0;
    memRdEn  = 1'b0;
    addrWord = wordIdx;
    unique case (state)
      ST_LOAD: begin
        strb.load    = 1'b1;
        strb.setFlag = 1'b1;
        strb.flagBit = (wordIdx == '0);
        strb.clkFall = 1'b1;
        memRdEn      = 1'b1;
      end
      ST_SHIFT: begin
        if (!phase) begin
          strb.clkRise = 1'b1;
        end else begin
          strb.clkFall = 1'b1;
          if (!lastBit) begin
            if (bitIdx < DATA_END) strb.shiftOut = 1'b1;
            else                   strb.setZero  = 1'b1;
          end else if (!lastWord) begin
            strb.load    = 1'b1;
            strb.setFlag = 1'b1;
            strb.flagBit = 1'b0;
            memRdEn      = 1'b1;
            addrWord     = wordIdx + 1'b1;
          end else begin
            strb.setZero = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
      bitIdx  <= '0;
      phase   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (passStart && monEn) begin
            state   <= ST_LOAD;
            wordIdx <= '0;
          end
        end
        ST_LOAD: begin
          state  <= ST_SHIFT;
          bitIdx <= '0;
          phase  <= 1'b0;
        end
        ST_SHIFT: begin
          phase <= ~phase;
          if (phase) begin
            if (!lastBit) begin
              bitIdx <= bitIdx + 1'b1;
            end else begin
              bitIdx <= '0;
              if (!lastWord) wordIdx <= wordIdx + 1'b1;
              else           state   <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted strobe fetches the first slot in the next cycle
  p_start_reads_r2: assert property (@(posedge clk) disable iff (!rstN)
    (idle && passStart && monEn) |=> (memRdEn && memAddr == slotAddr[0]));

  // R3: with the monitor disabled, the controller stays idle
  p_disabled_stays_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !monEn) |=> idle);

endmodule

// File: rtl/rtm_datapath.sv
module rtm_datapath
  import rtm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtmStrobe_t        strb,
  input  logic              ckOutEn,
  input  logic [DATA_W-1:0] memRdData,
  output logic              serData,
  output logic              serClk
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      serData  <= 1'b0;
    end else begin
      if (strb.load) shiftReg <= memRdData;
      if (strb.setFlag) begin
        serData <= strb.flagBit;
      end else if (strb.shiftOut) begin
        serData  <= shiftReg[DATA_W-1];
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end else if (strb.setZero) begin
        serData <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             serClk <= 1'b0;
    else if (strb.clkRise) serClk <= ckOutEn;
    else if (strb.clkFall) serClk <= 1'b0;
  end

  // R9: a high serial clock always follows an enabled rising request
  p_clk_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> $past(ckOutEn));

  // R4: the serial clock is high for exactly one cycle per bit period
  p_clk_half_period_r4: assert property (@(posedge clk) disable iff (!rstN)
    serClk |=> !serClk);

endmodule

// File: rtl/rtm_serializer.sv
module rtm_serializer
  import rtm_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter int TRAIL_BITS = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        monEn,
  input  logic                        ckOutEn,
  input  logic                        passStart,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slotSel,
  output logic                        memRdEn,
  output logic [ADDR_W-1:0]           memAddr,
  input  logic [DATA_W-1:0]           memRdData,
  output logic                        serData,
  output logic                        serClk
);

  rtmStrobe_t strb;
  logic       idle;

  rtm_ctrl #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .TRAIL_BITS(TRAIL_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .monEn    (monEn),
    .passStart(passStart),
    .slotSel  (slotSel),
    .memRdEn  (memRdEn),
    .memAddr  (memAddr),
    .idle     (idle),
    .strb     (strb)
  );

  rtm_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ckOutEn  (ckOutEn),
    .memRdData(memRdData),
    .serData  (serData),
    .serClk   (serClk)
  );

  // R8: both serial lines rest low while the controller is idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> (!serData && !serClk));

  // R5: the first word of a pass carries a high flag
  p_first_flag_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.flagBit) |=> serData);

  // R5: later words carry a low flag
  p_later_flag_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.flagBit) |=> !serData);

endmodule

// File: tb/rtm_serializer_tb.sv
`timescale 1ns/1ps
module rtm_serializer_tb;

  localparam int FRAME    = 35;
  localparam int WORD_CYC = 2 * FRAME;
  localparam int PASS_END = 4 * WORD_CYC + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        monEn = 1'b0;
  logic        ckOutEn = 1'b0;
  logic        passStart = 1'b0;
  logic [7:0]  slotSel = '0;
  logic        memRdEn;
  logic [1:0]  memAddr;
  logic [31:0] memRdData;
  logic        serData;
  logic        serClk;

  logic [31:0] mem [4];

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign memRdData = mem[memAddr];

  rtm_serializer u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .monEn    (monEn),
    .ckOutEn  (ckOutEn),
    .passStart(passStart),
    .slotSel  (slotSel),
    .memRdEn  (memRdEn),
    .memAddr  (memAddr),
    .memRdData(memRdData),
    .serData  (serData),
    .serClk   (serClk)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] slotOf(input int k);
    return slotSel[k*2 +: 2];
  endfunction

  // Behavioural reference: time since the accepted strobe decides every output.
  bit          mBusy;
  int          mT;
  logic [31:0] mWord;
  logic        mData, mClk, mRd;
  logic [1:0]  mAddr;
  string       mTag;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mT = 0; mWord = '0;
      mData = 0; mClk = 0; mRd = 0; mAddr = '0; mTag = "R8";
    end else begin
      if (mRd) mWord = mem[mAddr];
      if (mBusy) begin
        mT++;
        if (mT == PASS_END) mBusy = 0;
      end else if (passStart && monEn) begin
        mBusy = 1;
        mT = 0;
      end
      mRd = 0;
      if (!mBusy) begin
        mData = 0; mClk = 0; mTag = "R8";
      end else if (mT == 0) begin
        mData = 0; mClk = 0; mRd = 1; mAddr = slotOf(0); mTag = "R2";
      end else begin
        int u, w, r, b;
        u = mT - 1;
        w = u / WORD_CYC;
        r = u % WORD_CYC;
        b = r / 2;
        if (b == 0) begin
          mData = (w == 0); mTag = "R5";
        end else if (b <= 32) begin
          mData = mWord[32-b]; mTag = "R6";
        end else begin
          mData = 1'b0; mTag = "R6";
        end
        mClk = (r % 2 == 1) ? ckOutEn : 1'b0;
        if (r == WORD_CYC - 1 && w < 3) begin
          mRd = 1; mAddr = slotOf(w + 1);
        end
      end
    end
  end

  int rdCount = 0;
  int clkHighCount = 0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(mTag, "serData", 32'(serData), 32'(mData));
      chk("R9", "serClk", 32'(serClk), 32'(mClk));
      chk("R7", "memRdEn", 32'(memRdEn), 32'(mRd));
      if (mRd) chk("R7", "memAddr", 32'(memAddr), 32'(mAddr));
      if (memRdEn) rdCount++;
      if (serClk) clkHighCount++;
    end
  end

  task automatic pulseStart();
    @(posedge clk); #1 passStart = 1'b1;
    @(posedge clk); #1 passStart = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int rd0, ck0;
    mem[0] = 32'hA5C3_0F81;
    mem[1] = 32'h8000_0001;
    mem[2] = 32'hFFFF_FFFF;
    mem[3] = 32'h0000_0000;
    slotSel = {2'd1, 2'd3, 2'd0, 2'd2};
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet under reset
    chk("R1", "serData in reset", 32'(serData), 0);
    chk("R1", "serClk in reset", 32'(serClk), 0);
    chk("R1", "memRdEn in reset", 32'(memRdEn), 0);
    rstN = 1'b1;
    waitCycles(3);

    // R3: strobe while disabled starts nothing
    rd0 = rdCount;
    pulseStart();
    @(negedge clk);
    chk("R3", "memRdEn after disabled strobe", 32'(memRdEn), 0);
    waitCycles(300);
    chk("R3", "reads while disabled", 32'(rdCount - rd0), 0);
    chk("R3", "serData while disabled", 32'(serData), 0);

    // R2, R4, R10: enabled pass with a stray strobe in the middle
    monEn = 1'b1;
    ckOutEn = 1'b1;
    rd0 = rdCount;
    ck0 = clkHighCount;
    pulseStart();
    @(negedge clk);
    chk("R2", "memRdEn after start", 32'(memRdEn), 1);
    chk("R2", "memAddr after start", 32'(memAddr), 32'(slotSel[1:0]));
    waitCycles(100);
    pulseStart();
    waitCycles(300);
    chk("R10", "reads with mid-pass strobe", 32'(rdCount - rd0), 4);
    chk("R4", "serial clock pulses per pass", 32'(clkHighCount - ck0), 4 * FRAME);
    chk("R8", "serData after pass", 32'(serData), 0);

    // R9: clock enable toggled during a pass; all slots on one address
    slotSel = {2'd3, 2'd3, 2'd3, 2'd3};
    ckOutEn = 1'b0;
    pulseStart();
    waitCycles(120);
    ckOutEn = 1'b1;
    waitCycles(80);
    ckOutEn = 1'b0;
    waitCycles(100);
    chk("R9", "serClk idle", 32'(serClk), 0);

    // R11: enable dropped mid-pass, new memory contents
    mem[0] = 32'h0123_4567;
    mem[1] = 32'hFEDC_BA98;
    mem[2] = 32'h5555_AAAA;
    mem[3] = 32'h8000_0000;
    slotSel = {2'd0, 2'd1, 2'd2, 2'd3};
    ckOutEn = 1'b1;
    rd0 = rdCount;
    pulseStart();
    waitCycles(50);
    monEn = 1'b0;
    waitCycles(300);
    chk("R11", "reads after enable drop", 32'(rdCount - rd0), 4);

    // R10: strobe held high restarts only after each pass has ended
    monEn = 1'b1;
    rd0 = rdCount;
    @(posedge clk); #1 passStart = 1'b1;
    repeat (600) @(posedge clk);
    #1 passStart = 1'b0;
    waitCycles(300);
    chk("R10", "reads with held strobe", 32'(rdCount - rd0), 12);
    chk("R8", "serData at end", 32'(serData), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule